// File: doc/BRIEF.md
# DDR SDRAM Command Protocol Checker

This block watches the command bus of a single-rank DDR SDRAM and flags commands that break the protocol. On each rising clock edge it samples clock enable, the active-low chip select, row strobe, column strobe and write enable, the bank address and address bit 10. It decodes one command per cycle and tracks whether each of the four banks is open or closed. It also runs the spacing timers between commands. Each spacing limit is a cycle count set by a parameter.

Every sampled cycle produces a registered report, which becomes visible after the next rising edge. The report carries the decoded command, the bank address, a violation strobe and a 4-bit violation code. A command that breaks a rule is reported and then dropped from the tracked state, so one bad command does not hide the checks on the commands after it. The burst length comes from a configuration input that mirrors the mode register. It sets when a bank with auto precharge closes and how long a write with auto precharge locks out further column commands.

Top module: `ddr_guard_top`

## Requirements
- R1: Each cycle, after the next rising edge, `cmd_o` reports the decoded command and `bank_o` reports the sampled bank address. With chip select low, {RAS#,CAS#,WE#} decodes as 000 mode set (1), 001 refresh (2), 011 activate (3), 101 read (4), 100 write (5), 110 burst stop (6), 010 precharge (7), 111 no-op (0). Chip select high decodes as no-op (0). `viol_o` is high exactly when `viol_code_o` is non-zero.
- R2: The bank address selects one of four banks, each tracked as open or closed. A read or write to a closed bank gives code 5. An activate to an open bank gives code 6.
- R3: A precharge with A10 high closes every open bank and ignores the bank address. With A10 low it closes only the addressed bank.
- R4: A read or write with A10 high closes its bank by itself BL/2 cycles after the command. The burst length select is 10 for BL4, 11 for BL8, and 00 or 01 for BL2.
- R5: Mode set, refresh and self-refresh entry while any bank is open give code 4.
- R6: A command other than no-op within TMRD cycles after an accepted mode set gives code 2.
- R7: The refresh encoding sampled with clock enable falling (high in the previous cycle, low now) enters self refresh and is reported as command 8. Inside self refresh, any command other than a no-op or deselect gives code 1. A no-op with clock enable high leaves self refresh and is reported as command 9.
- R8: After an accepted write with auto precharge, a read or write to any bank before the burst ends gives code 12. An activate of that bank earlier than TRP cycles after the burst end gives code 9.
- R9: A read or write earlier than TRCD cycles after its bank's activate gives code 7. A precharge that would close a bank earlier than TRAS cycles after its activate gives code 8.
- R10: An activate earlier than TRP cycles after its bank closed gives code 9. One earlier than TRC cycles after the same bank's activate gives code 10. One earlier than TRRD cycles after any accepted activate gives code 11.
- R11: A command other than no-op within TRFC cycles after an accepted refresh gives code 3.
- R12: When several rules fail, the lowest code among 1, 2, 3 wins, followed by the command-specific checks in the order 12, 5, 7 for column commands and 6, 9, 10, 11 for activate. A rejected command changes no bank state and no timer. Reset closes all banks and clears every timer and the report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable as seen on the bus |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address |
| a10_i | input | 1 | Address bit 10 (precharge-all / auto precharge) |
| bl_sel_i | input | 2 | Burst length select |
| viol_o | output | 1 | Violation strobe for the reported cycle |
| viol_code_o | output | 4 | Violation code, 0 when legal |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 2 | Sampled bank address |

## Verification
A single command stream walks every spacing rule one cycle short of its limit and then exactly at it, so an off-by-one in any timer changes the outcome. Some pairs are chosen so that only one rule separates them: an early activate after an auto precharge fails the row-cycle rule while precharge spacing is already met. Other cases overlap several rules on purpose, to pin down the priority order. Directed sequences compare a single-bank precharge with a precharge-all, run BL2 and BL8 auto-precharge closes, and apply reset in the middle of traffic.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;
  typedef enum logic [3:0] {
    CMD_NOP = 4'd0, CMD_MRS = 4'd1, CMD_REF = 4'd2, CMD_ACT = 4'd3,
    CMD_RD  = 4'd4, CMD_WR  = 4'd5, CMD_BST = 4'd6, CMD_PRE = 4'd7,
    CMD_SRE = 4'd8, CMD_SRX = 4'd9
  } cmd_e;

  typedef enum logic [3:0] {
    V_NONE = 4'd0, V_SR = 4'd1, V_MRD = 4'd2, V_RFC = 4'd3,
    V_NOT_IDLE = 4'd4, V_BANK_IDLE = 4'd5, V_BANK_OPEN = 4'd6,
    V_RCD = 4'd7, V_RAS = 4'd8, V_RP = 4'd9, V_RC = 4'd10,
    V_RRD = 4'd11, V_WAP = 4'd12
  } viol_e;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_guard_pkg::*;
(
  input  logic cke_i,
  input  logic cke_q_i,
  input  logic in_sr_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  cmd_e base;

  always_comb begin
    base = CMD_NOP;
    if (!cs_ni) begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b000:  base = CMD_MRS;
        3'b001:  base = CMD_REF;
        3'b011:  base = CMD_ACT;
        3'b101:  base = CMD_RD;
        3'b100:  base = CMD_WR;
        3'b110:  base = CMD_BST;
        3'b010:  base = CMD_PRE;
        default: base = CMD_NOP;
      endcase
    end
    cmd_o = base;
    // refresh with falling clock enable enters self refresh
    if (!in_sr_i && cke_q_i && !cke_i && base == CMD_REF) cmd_o = CMD_SRE;
    if (in_sr_i && cke_i && base == CMD_NOP) cmd_o = CMD_SRX;
  end
endmodule

// File: rtl/ddr_bank_slot.sv
module ddr_bank_slot #(
  parameter int TRCD = 2,
  parameter int TRP  = 2,
  parameter int TRAS = 6,
  parameter int TRC  = 8,
  parameter int CW   = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       act_i,
  input  logic       col_i,
  input  logic       ap_i,
  input  logic       pre_i,
  input  logic [3:0] half_bl_i,
  output logic       open_o,
  output logic       rcd_busy_o,
  output logic       ras_busy_o,
  output logic       rp_busy_o,
  output logic       rc_busy_o
);
  logic [CW-1:0] rcd_q, ras_q, rp_q, rc_q;
  logic [3:0]    apc_q;
  logic          open_q;
  logic          ap_close;

  assign ap_close = (apc_q == 4'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      rcd_q  <= '0;
      ras_q  <= '0;
      rp_q   <= '0;
      rc_q   <= '0;
      apc_q  <= '0;
    end else begin
      rcd_q <= act_i ? CW'(TRCD - 1) : (rcd_q != 0 ? rcd_q - 1'b1 : rcd_q);
      ras_q <= act_i ? CW'(TRAS - 1) : (ras_q != 0 ? ras_q - 1'b1 : ras_q);
      rc_q  <= act_i ? CW'(TRC - 1)  : (rc_q  != 0 ? rc_q  - 1'b1 : rc_q);
      rp_q  <= ((pre_i && open_q) || ap_close) ? CW'(TRP - 1)
                                               : (rp_q != 0 ? rp_q - 1'b1 : rp_q);
      apc_q <= (col_i && ap_i) ? half_bl_i : (apc_q != 0 ? apc_q - 1'b1 : apc_q);
      if (act_i)                 open_q <= 1'b1;
      else if (pre_i || ap_close) open_q <= 1'b0;
    end
  end

  assign open_o     = open_q;
  assign rcd_busy_o = (rcd_q != 0);
  assign ras_busy_o = (ras_q != 0);
  assign rp_busy_o  = (rp_q  != 0);
  assign rc_busy_o  = (rc_q  != 0);
endmodule

// File: rtl/ddr_guard_top.sv
module ddr_guard_top
  import ddr_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TRCD = 2,
  parameter int TRP  = 2,
  parameter int TRAS = 6,
  parameter int TRC  = 8,
  parameter int TRRD = 2,
  parameter int TRFC = 10,
  parameter int TMRD = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cke_i,
  input  logic       cs_ni,
  input  logic       ras_ni,
  input  logic       cas_ni,
  input  logic       we_ni,
  input  logic [1:0] ba_i,
  input  logic       a10_i,
  input  logic [1:0] bl_sel_i,
  output logic       viol_o,
  output logic [3:0] viol_code_o,
  output logic [3:0] cmd_o,
  output logic [1:0] bank_o
);
  localparam int M1   = (TRCD > TRP) ? TRCD : TRP;
  localparam int M2   = (TRAS > TRC) ? TRAS : TRC;
  localparam int M3   = (TRFC > TRRD) ? TRFC : TRRD;
  localparam int M4   = (M1 > M2) ? M1 : M2;
  localparam int M5   = (M3 > TMRD) ? M3 : TMRD;
  localparam int TMAX = (M4 > M5) ? M4 : M5;
  localparam int CW   = $clog2(TMAX + 1);

  cmd_e          cmd;
  viol_e         vcode;
  logic          ok, cke_q, sr_q, pre_all_go, is_nop;
  logic [CW-1:0] mrd_q, rfc_q, rrd_q;
  logic [3:0]    wap_q, half_bl;
  logic [NUM_BANKS-1:0] open_v, rcd_b, ras_b, rp_b, rc_b;
  logic [NUM_BANKS-1:0] act_go, col_go, pre_go;

  ddr_cmd_decode u_dec (
    .cke_i   (cke_i),
    .cke_q_i (cke_q),
    .in_sr_i (sr_q),
    .cs_ni   (cs_ni),
    .ras_ni  (ras_ni),
    .cas_ni  (cas_ni),
    .we_ni   (we_ni),
    .cmd_o   (cmd)
  );

  always_comb begin
    unique case (bl_sel_i)
      2'b10:   half_bl = 4'd2;
      2'b11:   half_bl = 4'd4;
      default: half_bl = 4'd1;
    endcase
  end

  assign is_nop = (cmd == CMD_NOP) || (cmd == CMD_SRX);

  always_comb begin
    vcode = V_NONE;
    if (sr_q && !is_nop)           vcode = V_SR;
    else if (mrd_q != 0 && !is_nop) vcode = V_MRD;
    else if (rfc_q != 0 && !is_nop) vcode = V_RFC;
    else begin
      unique case (cmd)
        CMD_MRS, CMD_REF, CMD_SRE:
          if (|open_v) vcode = V_NOT_IDLE;
        CMD_RD, CMD_WR:
          if (wap_q != 0)          vcode = V_WAP;
          else if (!open_v[ba_i])  vcode = V_BANK_IDLE;
          else if (rcd_b[ba_i])    vcode = V_RCD;
        CMD_ACT:
          if (open_v[ba_i])        vcode = V_BANK_OPEN;
          else if (rp_b[ba_i])     vcode = V_RP;
          else if (rc_b[ba_i])     vcode = V_RC;
          else if (rrd_q != 0)     vcode = V_RRD;
        CMD_PRE:
          if (a10_i ? |(open_v & ras_b) : (open_v[ba_i] && ras_b[ba_i]))
            vcode = V_RAS;
        default: vcode = V_NONE;
      endcase
    end
  end

  assign ok         = (vcode == V_NONE);
  assign pre_all_go = ok && (cmd == CMD_PRE) && a10_i;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit       = (ba_i == 2'(b));
    assign act_go[b] = ok && (cmd == CMD_ACT) && hit;
    assign col_go[b] = ok && (cmd == CMD_RD || cmd == CMD_WR) && hit;
    assign pre_go[b] = ok && (cmd == CMD_PRE) && (a10_i || hit);

    ddr_bank_slot #(
      .TRCD (TRCD), .TRP (TRP), .TRAS (TRAS), .TRC (TRC), .CW (CW)
    ) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .act_i      (act_go[b]),
      .col_i      (col_go[b]),
      .ap_i       (a10_i),
      .pre_i      (pre_go[b]),
      .half_bl_i  (half_bl),
      .open_o     (open_v[b]),
      .rcd_busy_o (rcd_b[b]),
      .ras_busy_o (ras_b[b]),
      .rp_busy_o  (rp_b[b]),
      .rc_busy_o  (rc_b[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q       <= 1'b1;
      sr_q        <= 1'b0;
      mrd_q       <= '0;
      rfc_q       <= '0;
      rrd_q       <= '0;
      wap_q       <= '0;
      viol_o      <= 1'b0;
      viol_code_o <= '0;
      cmd_o       <= '0;
      bank_o      <= '0;
    end else begin
      cke_q <= cke_i;
      mrd_q <= (ok && cmd == CMD_MRS) ? CW'(TMRD - 1) : (mrd_q != 0 ? mrd_q - 1'b1 : mrd_q);
      rfc_q <= (ok && cmd == CMD_REF) ? CW'(TRFC - 1) : (rfc_q != 0 ? rfc_q - 1'b1 : rfc_q);
      rrd_q <= (ok && cmd == CMD_ACT) ? CW'(TRRD - 1) : (rrd_q != 0 ? rrd_q - 1'b1 : rrd_q);
      wap_q <= (ok && cmd == CMD_WR && a10_i) ? half_bl - 4'd1
                                              : (wap_q != 0 ? wap_q - 1'b1 : wap_q);
      if (ok && cmd == CMD_SRE)      sr_q <= 1'b1;
      else if (cmd == CMD_SRX)       sr_q <= 1'b0;
      viol_o      <= !ok;
      viol_code_o <= vcode;
      cmd_o       <= cmd;
      bank_o      <= ba_i;
    end
  end
endmodule

// File: rtl/ddr_guard_chk.sv
module ddr_guard_chk #(
  parameter int NB = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          viol_o,
  input logic [3:0]    viol_code_o,
  input logic [NB-1:0] open_v,
  input logic [NB-1:0] act_go,
  input logic          pre_all_go,
  input logic          sr_q,
  input logic [3:0]    cmd
);
  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_code_o <= 4'd12); // R12

  AST_STROBE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o == (viol_code_o != 4'd0)); // R1

  AST_ONE_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_go)); // R2

  AST_ACT_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|act_go) |=> ((open_v & $past(act_go)) == $past(act_go))); // R2

  AST_PRE_ALL_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_all_go |=> (open_v == '0)); // R3

  AST_SR_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_q && cmd != 4'd0 && cmd != 4'd9) |=> (viol_o && viol_code_o == 4'd1)); // R7

  AST_MRS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 4'd1 && (|open_v)) |=> viol_o); // R5
endmodule

bind ddr_guard_top ddr_guard_chk #(.NB(NUM_BANKS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .viol_o      (viol_o),
  .viol_code_o (viol_code_o),
  .open_v      (open_v),
  .act_go      (act_go),
  .pre_all_go  (pre_all_go),
  .sr_q        (sr_q),
  .cmd         (cmd)
);

// File: tb/tb_ddr_guard_top.sv
module tb_ddr_guard_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 44;

  localparam logic [2:0] K_MRS = 3'b000, K_REF = 3'b001, K_PRE = 3'b010,
                         K_ACT = 3'b011, K_WR  = 3'b100, K_RD  = 3'b101,
                         K_BST = 3'b110, K_NOP = 3'b111;

  // {cke, cs_n, rcw[2:0], ba[1:0], a10, exp_code[3:0], exp_cmd[3:0]}, BL4
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b1,1'b0,K_ACT,2'd0,1'b0,4'd0, 4'd3},  // 0  R1 act b0
    {1'b1,1'b0,K_RD ,2'd0,1'b0,4'd7, 4'd4},  // 1  R9 tRCD short
    {1'b1,1'b0,K_RD ,2'd0,1'b0,4'd0, 4'd4},  // 2  R9 tRCD met
    {1'b1,1'b0,K_ACT,2'd1,1'b0,4'd0, 4'd3},  // 3  R10 tRRD met
    {1'b1,1'b0,K_ACT,2'd1,1'b0,4'd6, 4'd3},  // 4  R2 already open
    {1'b1,1'b0,K_PRE,2'd0,1'b0,4'd8, 4'd7},  // 5  R9 tRAS short
    {1'b1,1'b0,K_PRE,2'd0,1'b0,4'd0, 4'd7},  // 6  R9 tRAS met
    {1'b1,1'b0,K_ACT,2'd0,1'b0,4'd9, 4'd3},  // 7  R10 tRP short
    {1'b1,1'b0,K_ACT,2'd0,1'b0,4'd0, 4'd3},  // 8  R10 tRP/tRC met
    {1'b1,1'b0,K_RD ,2'd2,1'b0,4'd5, 4'd4},  // 9  R2 idle bank
    {1'b1,1'b0,K_MRS,2'd0,1'b0,4'd4, 4'd1},  // 10 R5 banks open
    {1'b1,1'b0,K_ACT,2'd2,1'b0,4'd0, 4'd3},  // 11
    {1'b1,1'b0,K_ACT,2'd3,1'b0,4'd11,4'd3},  // 12 R10 tRRD short
    {1'b1,1'b0,K_RD ,2'd2,1'b1,4'd0, 4'd4},  // 13 R4 read with AP
    {1'b1,1'b0,K_NOP,2'd0,1'b0,4'd0, 4'd0},  // 14
    {1'b1,1'b0,K_NOP,2'd0,1'b0,4'd0, 4'd0},  // 15 R4 bank 2 closes here
    {1'b1,1'b0,K_ACT,2'd2,1'b0,4'd9, 4'd3},  // 16 R10 tRP after AP
    {1'b1,1'b0,K_ACT,2'd2,1'b0,4'd10,4'd3},  // 17 R10 tRC short
    {1'b1,1'b0,K_NOP,2'd0,1'b0,4'd0, 4'd0},  // 18
    {1'b1,1'b0,K_ACT,2'd2,1'b0,4'd0, 4'd3},  // 19 R10 tRC met
    {1'b1,1'b0,K_WR ,2'd1,1'b1,4'd0, 4'd5},  // 20 R8 write with AP
    {1'b1,1'b0,K_RD ,2'd0,1'b0,4'd12,4'd4},  // 21 R8 lockout
    {1'b1,1'b0,K_RD ,2'd0,1'b0,4'd0, 4'd4},  // 22 R8 burst ended
    {1'b1,1'b0,K_ACT,2'd1,1'b0,4'd9, 4'd3},  // 23 R8 tRP after write AP
    {1'b1,1'b0,K_PRE,2'd0,1'b1,4'd8, 4'd7},  // 24 R3 all: bank 2 tRAS
    {1'b1,1'b0,K_PRE,2'd0,1'b1,4'd0, 4'd7},  // 25 R3 precharge all
    {1'b1,1'b0,K_REF,2'd0,1'b0,4'd0, 4'd2},  // 26 R5 all idle
    {1'b1,1'b0,K_ACT,2'd0,1'b0,4'd3, 4'd3},  // 27 R11 tRFC short
    {1'b1,1'b0,K_NOP,2'd0,1'b0,4'd0, 4'd0},  // 28 R11 nop allowed
    {1'b1,1'b1,K_ACT,2'd0,1'b0,4'd0, 4'd0},  // 29 R1 deselect
    {1'b1,1'b0,K_NOP,2'd0,1'b0,4'd0, 4'd0},  // 30
    {1'b1,1'b1,K_MRS,2'd1,1'b0,4'd0, 4'd0},  // 31 R1 deselect
    {1'b1,1'b0,K_NOP,2'd0,1'b0,4'd0, 4'd0},  // 32
    {1'b1,1'b0,K_NOP,2'd0,1'b0,4'd0, 4'd0},  // 33
    {1'b1,1'b0,K_NOP,2'd0,1'b0,4'd0, 4'd0},  // 34
    {1'b1,1'b0,K_NOP,2'd0,1'b0,4'd0, 4'd0},  // 35
    {1'b1,1'b0,K_MRS,2'd0,1'b0,4'd0, 4'd1},  // 36 R11 tRFC met
    {1'b1,1'b0,K_REF,2'd0,1'b0,4'd2, 4'd2},  // 37 R6 tMRD short
    {1'b0,1'b0,K_REF,2'd0,1'b0,4'd0, 4'd8},  // 38 R7 self refresh entry
    {1'b0,1'b0,K_ACT,2'd0,1'b0,4'd1, 4'd3},  // 39 R7 command in SR
    {1'b0,1'b1,K_NOP,2'd0,1'b0,4'd0, 4'd0},  // 40 R7 deselect in SR
    {1'b1,1'b0,K_NOP,2'd0,1'b0,4'd0, 4'd9},  // 41 R7 exit
    {1'b1,1'b0,K_ACT,2'd0,1'b0,4'd0, 4'd3},  // 42 R12 rejected ACT left no trace
    {1'b1,1'b0,K_BST,2'd0,1'b0,4'd0, 4'd6}   // 43 R1 burst stop
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cke_i = 1'b1, cs_ni = 1'b1, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1;
  logic [1:0] ba_i = '0;
  logic a10_i = 1'b0;
  logic [1:0] bl_sel_i = 2'b10;
  logic viol_o;
  logic [3:0] viol_code_o, cmd_o;
  logic [1:0] bank_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ddr_guard_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cke_i(cke_i), .cs_ni(cs_ni),
    .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni), .ba_i(ba_i),
    .a10_i(a10_i), .bl_sel_i(bl_sel_i), .viol_o(viol_o),
    .viol_code_o(viol_code_o), .cmd_o(cmd_o), .bank_o(bank_o)
  );

  function automatic string req_of(input logic [3:0] code);
    case (code)
      4'd1:  return "R7";
      4'd2:  return "R6";
      4'd3:  return "R11";
      4'd4:  return "R5";
      4'd5, 4'd6: return "R2";
      4'd7, 4'd8: return "R9";
      4'd9, 4'd10, 4'd11: return "R10";
      4'd12: return "R8";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic issue(input logic cke, input logic csn, input logic [2:0] rcw,
                       input logic [1:0] ba, input logic a10);
    cke_i = cke; cs_ni = csn; {ras_ni, cas_ni, we_ni} = rcw; ba_i = ba; a10_i = a10;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic expect_code(input string req, input int code);
    check(req, "viol_code_o", int'(viol_code_o), code);
    check(req, "viol_o", int'(viol_o), int'(code != 0));
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) issue(1'b1, 1'b0, K_NOP, 2'd0, 1'b0);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    cke_i = 1'b1; cs_ni = 1'b1; {ras_ni, cas_ni, we_ni} = K_NOP; ba_i = '0; a10_i = 1'b0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    do_reset();
    // R12 reset state
    expect_code("R12", 0);
    check("R12", "cmd_o", int'(cmd_o), 0);
    check("R12", "bank_o", int'(bank_o), 0);

    bl_sel_i = 2'b10;
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] v;
      v = VEC[i];
      issue(v[15], v[14], v[13:11], v[10:9], v[8]);
      expect_code(req_of(v[7:4]), int'(v[7:4]));
      check("R1", "cmd_o", int'(cmd_o), int'(v[3:0]));
      check("R1", "bank_o", int'(bank_o), int'(v[10:9]));
    end

    // R3: single-bank precharge leaves other banks open
    do_reset();
    issue(1'b1, 1'b0, K_ACT, 2'd0, 1'b0);
    nops(1);
    issue(1'b1, 1'b0, K_ACT, 2'd1, 1'b0);
    nops(4);
    issue(1'b1, 1'b0, K_PRE, 2'd0, 1'b0);
    expect_code("R3", 0);
    issue(1'b1, 1'b0, K_RD, 2'd1, 1'b0);
    expect_code("R3", 0);
    issue(1'b1, 1'b0, K_RD, 2'd0, 1'b0);
    expect_code("R3", 5);

    // R4: BL8 auto precharge closes after four cycles
    do_reset();
    bl_sel_i = 2'b11;
    issue(1'b1, 1'b0, K_ACT, 2'd3, 1'b0);
    nops(1);
    issue(1'b1, 1'b0, K_RD, 2'd3, 1'b1);
    expect_code("R4", 0);
    nops(2);
    issue(1'b1, 1'b0, K_RD, 2'd3, 1'b0);
    expect_code("R4", 0);
    nops(1);
    issue(1'b1, 1'b0, K_RD, 2'd3, 1'b0);
    expect_code("R4", 5);

    // R4/R8: BL2 (select 00) write with AP, one-cycle burst
    do_reset();
    bl_sel_i = 2'b00;
    issue(1'b1, 1'b0, K_ACT, 2'd1, 1'b0);
    nops(1);
    issue(1'b1, 1'b0, K_WR, 2'd1, 1'b1);
    expect_code("R8", 0);
    issue(1'b1, 1'b0, K_RD, 2'd1, 1'b0);
    expect_code("R8", 0);
    issue(1'b1, 1'b0, K_RD, 2'd1, 1'b0);
    expect_code("R4", 5);

    // R12: reset mid-traffic clears banks and timers
    bl_sel_i = 2'b10;
    issue(1'b1, 1'b0, K_ACT, 2'd0, 1'b0);
    issue(1'b1, 1'b0, K_REF, 2'd0, 1'b0);
    expect_code("R5", 4);
    do_reset();
    expect_code("R12", 0);
    issue(1'b1, 1'b0, K_RD, 2'd0, 1'b0);
    expect_code("R12", 5);
    issue(1'b1, 1'b0, K_ACT, 2'd0, 1'b0);
    expect_code("R12", 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule